// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block buffers outgoing audio samples between a 32-bit register-write port and a stereo codec sink. Each written word becomes one or two samples. Every sample is normalised to a 20-bit value, aligned to the most significant bit and padded with zeros, and is held one per entry in a circular buffer of `DEPTH` entries. In packed mode a single word carries two 16-bit or two 12-bit samples. The 18-bit and 20-bit sizes always use one sample per word.

The sink takes left/right pairs over a valid/ready handshake. A transfer burst starts once the buffer holds at least half its depth, transmission is enabled, and at least one audio slot is selected. The burst then continues while two or more entries remain. It ends early at the first pair the sink refuses after the level has fallen below half. The block keeps empty, half-empty, full and underrun flags. It derives a three-bit interrupt status from them and drives one masked interrupt line.

Top module: `audtx_fifo`

## Requirements
- R1: After `rst`, `st_empty`=1, `st_half`=1, `st_full`=0, `st_underrun`=0 and `snk_valid`=0.
- R2: `size_sel` encodes 0=16, 1=18, 2=20 and 3=12 bits. In one-per-word mode a sample is taken from the low bits of the word and shifted left by 20 minus its size. The stored value is masked to 20 bits.
- R3: With `compact_req`=1 and 16-bit or 12-bit size, each word yields two samples. Bits 15:0 are stored before bits 31:16. Each half is shifted left by 4 (16-bit) or by 8 (12-bit, low 12 bits of the half).
- R4: With 18-bit or 20-bit size, `compact_req` has no effect and each word yields one sample padded as in R2.
- R5: A one-per-word write is accepted only when level < DEPTH. A packed write is accepted only when level+2 < DEPTH. Any other write is dropped and leaves the contents unchanged.
- R6: After an accepted write, empty and underrun clear. Half-empty clears if level >= DEPTH/2. Full sets if level = DEPTH.
- R7: `snk_valid` rises only when `tx_en`=1, `slot_sel`≠0 and level >= DEPTH/2. A pair carries the oldest entry as `snk_left` and the next as `snk_right`. The burst continues while two or more entries remain. Below half, a cycle with `snk_valid`=1 and `snk_ready`=0 ends the burst.
- R8: After a pair leaves, full clears. Half-empty sets if level <= DEPTH/2. When the level reaches zero, empty and underrun both set.
- R9: A pulse on `ur_clear` clears the underrun flag.
- R10: `irq_status` bit 0 = underrun, bit 1 = half-empty, bit 2 = empty AND NOT `link_busy`. `irq` is the OR of `irq_status & irq_en`.
- R11: Holding `iface_en` low for a clock discards all contents and restores the R1 flag state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iface_en | input | 1 | Interface enable; low clears all state |
| tx_en | input | 1 | Transmit enable |
| slot_sel | input | 2 | Audio slot selects; any set bit allows draining |
| size_sel | input | 2 | Sample size code |
| compact_req | input | 1 | Request two samples per word |
| wr_valid | input | 1 | Word write strobe |
| wr_data | input | 32 | Written word |
| ur_clear | input | 1 | Underrun clear pulse |
| link_busy | input | 1 | Codec link still shifting data |
| irq_en | input | 3 | Interrupt enables per status bit |
| snk_valid | output | 1 | Pair offered to sink |
| snk_ready | input | 1 | Sink accepts the pair |
| snk_left | output | 20 | Left sample |
| snk_right | output | 20 | Right sample |
| st_empty | output | 1 | Empty flag |
| st_half | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |
| irq_status | output | 3 | Raw interrupt status |
| irq | output | 1 | Masked interrupt line |

## Verification
The assertions make almost no assumption about the inputs. They do rely on `size_sel` being read as its 2-bit code on the same cycle as the write. They also rely on the write strobe being the only thing that can add entries, so a refused pair with no write in that cycle must leave the level unchanged. The stimulus changes size and packing only after an interface-disable cycle, while transmission is off and the buffer is empty. Each sweep therefore starts from a known level, and the bench can track that level by applying the acceptance rule itself.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

    localparam int SAMPLE_W = 20;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = 16;

    typedef enum logic [1:0] {
        SZ_16 = 2'd0,
        SZ_18 = 2'd1,
        SZ_20 = 2'd2,
        SZ_12 = 2'd3
    } sample_size_e;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        logic underrun;
        logic full;
        logic half;
        logic empty;
    } txflags_t;

    typedef struct packed {
        logic complete;
        logic tx;
        logic underrun;
    } irqvec_t;

    function automatic logic packing_allowed(sample_size_e sz);
        return (sz == SZ_16) || (sz == SZ_12);
    endfunction

    function automatic sample_t pad_word(sample_size_e sz, logic [WORD_W-1:0] w);
        sample_t r;
        case (sz)
            SZ_12:   r = {w[11:0], 8'h00};
            SZ_16:   r = {w[15:0], 4'h0};
            SZ_18:   r = {w[17:0], 2'b00};
            default: r = w[SAMPLE_W-1:0];
        endcase
        return r;
    endfunction

    function automatic sample_t pad_half(sample_size_e sz, logic [HALF_W-1:0] h);
        return (sz == SZ_12) ? {h[11:0], 8'h00} : {h, 4'h0};
    endfunction

endpackage

// File: rtl/audtx_unpack.sv
module audtx_unpack
    import audtx_pkg::*;
(
    input  sample_size_e          size,
    input  logic                  compact_req,
    input  logic [WORD_W-1:0]     word,
    output logic                  packed_eff,
    output sample_t               first,
    output sample_t               second
);

    always_comb begin
        packed_eff = compact_req && packing_allowed(size);
        if (packed_eff) begin
            first  = pad_half(size, word[HALF_W-1:0]);
            second = pad_half(size, word[WORD_W-1:HALF_W]);
        end else begin
            first  = pad_word(size, word);
            second = '0;
        end
    end

endmodule

// File: rtl/audtx_ring.sv
module audtx_ring
    import audtx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    clr,
    input  logic    put_one,
    input  logic    put_two,
    input  sample_t wd0,
    input  sample_t wd1,
    input  logic    take_pair,
    output sample_t rd0,
    output sample_t rd1
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] STEP1 = AW'(1);
    localparam logic [AW-1:0] STEP2 = AW'(2);

    sample_t       mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;

    always_ff @(posedge clk) begin
        if (clr) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (put_two)      wp <= wp + STEP2;
            else if (put_one) wp <= wp + STEP1;
            if (take_pair)    rp <= rp + STEP2;
        end
    end

    always_ff @(posedge clk) begin
        if (put_one || put_two) mem[wp] <= wd0;
        if (put_two)            mem[wp + STEP1] <= wd1;
    end

    assign rd0 = mem[rp];
    assign rd1 = mem[rp + STEP1];

endmodule

// File: rtl/audtx_flags.sv
module audtx_flags
    import audtx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       clr,
    input  logic                       push,
    input  logic [$clog2(DEPTH):0]     lvl_pushed,
    input  logic                       pop,
    input  logic [$clog2(DEPTH):0]     lvl_final,
    input  logic                       uclr_req,
    input  logic                       busy,
    input  logic [2:0]                 irq_en,
    output txflags_t                   flags,
    output irqvec_t                    ist,
    output logic                       irq
);

    localparam int LW = $clog2(DEPTH) + 1;
    localparam logic [LW-1:0] HALF_L  = LW'(DEPTH / 2);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    txflags_t flg;
    txflags_t nxt;

    always_comb begin
        nxt = flg;
        if (uclr_req) nxt.underrun = 1'b0;
        if (push) begin
            if (lvl_pushed != '0) begin
                nxt.empty    = 1'b0;
                nxt.underrun = 1'b0;
            end
            if (lvl_pushed >= HALF_L)  nxt.half = 1'b0;
            if (lvl_pushed >= DEPTH_L) nxt.full = 1'b1;
        end
        if (pop) begin
            nxt.full = 1'b0;
            if (lvl_final <= HALF_L) nxt.half = 1'b1;
            if (lvl_final == '0) begin
                nxt.empty    = 1'b1;
                nxt.underrun = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) flg <= '{underrun: 1'b0, full: 1'b0, half: 1'b1, empty: 1'b1};
        else     flg <= nxt;
    end

    assign flags = flg;
    assign ist   = '{complete: (!busy && flg.empty), tx: flg.half, underrun: flg.underrun};
    assign irq   = |(ist & irq_en);

    AST_UNDERRUN_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (clr)
        flg.underrun |-> flg.empty); // R8
    AST_PUSH_LEAVES_DATA: assert property (@(posedge clk) disable iff (clr)
        push |=> !flg.empty); // R6
    AST_UCLR_WORKS: assert property (@(posedge clk) disable iff (clr)
        (uclr_req && !pop) |=> !flg.underrun); // R9

endmodule

// File: rtl/audtx_fifo.sv
module audtx_fifo
    import audtx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        iface_en,
    input  logic        tx_en,
    input  logic [1:0]  slot_sel,
    input  logic [1:0]  size_sel,
    input  logic        compact_req,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    input  logic        ur_clear,
    input  logic        link_busy,
    input  logic [2:0]  irq_en,
    output logic        snk_valid,
    input  logic        snk_ready,
    output logic [19:0] snk_left,
    output logic [19:0] snk_right,
    output logic        st_empty,
    output logic        st_half,
    output logic        st_full,
    output logic        st_underrun,
    output logic [2:0]  irq_status,
    output logic        irq
);

    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
    localparam logic [LW-1:0] HALF_L  = LW'(DEPTH / 2);
    localparam logic [LW-1:0] ONE_L   = LW'(1);
    localparam logic [LW-1:0] TWO_L   = LW'(2);
    localparam logic [LW:0]   DEPTH_X = (LW+1)'(DEPTH);
    localparam logic [LW:0]   TWO_X   = (LW+1)'(2);

    logic         clr;
    sample_size_e sz;
    logic         packed_eff;
    sample_t      s_first;
    sample_t      s_second;
    logic [LW-1:0] level;
    logic [LW-1:0] lvl_pushed;
    logic [LW-1:0] lvl_final;
    logic         accept;
    logic         put_one;
    logic         put_two;
    logic         drain_ok;
    logic         pop;
    logic         burst_q;
    txflags_t     flags;
    irqvec_t      ist;

    assign clr = rst || !iface_en;
    assign sz  = sample_size_e'(size_sel);

    audtx_unpack u_unpack (
        .size        (sz),
        .compact_req (compact_req),
        .word        (wr_data),
        .packed_eff  (packed_eff),
        .first       (s_first),
        .second      (s_second)
    );

    always_comb begin
        if (packed_eff) accept = wr_valid && (({1'b0, level} + TWO_X) < DEPTH_X);
        else            accept = wr_valid && (level < DEPTH_L);
    end
    assign put_two = accept && packed_eff;
    assign put_one = accept && !packed_eff;

    assign drain_ok  = tx_en && (slot_sel != 2'b00);
    assign snk_valid = drain_ok && (level >= TWO_L) && ((level >= HALF_L) || burst_q);
    assign pop       = snk_valid && snk_ready;

    always_comb begin
        lvl_pushed = level;
        if (put_two)      lvl_pushed = level + TWO_L;
        else if (put_one) lvl_pushed = level + ONE_L;
        lvl_final = pop ? (lvl_pushed - TWO_L) : lvl_pushed;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            level   <= '0;
            burst_q <= 1'b0;
        end else begin
            level   <= lvl_final;
            burst_q <= pop && (lvl_final >= TWO_L);
        end
    end

    audtx_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .clr       (clr),
        .put_one   (put_one),
        .put_two   (put_two),
        .wd0       (s_first),
        .wd1       (s_second),
        .take_pair (pop),
        .rd0       (snk_left),
        .rd1       (snk_right)
    );

    audtx_flags #(.DEPTH(DEPTH)) u_flags (
        .clk        (clk),
        .clr        (clr),
        .push       (accept),
        .lvl_pushed (lvl_pushed),
        .pop        (pop),
        .lvl_final  (lvl_final),
        .uclr_req   (ur_clear),
        .busy       (link_busy),
        .irq_en     (irq_en),
        .flags      (flags),
        .ist        (ist),
        .irq        (irq)
    );

    assign st_empty    = flags.empty;
    assign st_half     = flags.half;
    assign st_full     = flags.full;
    assign st_underrun = flags.underrun;
    assign irq_status  = ist;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (clr)
        level <= DEPTH_L); // R5
    AST_FULL_AT_DEPTH: assert property (@(posedge clk) disable iff (clr)
        st_full == (level == DEPTH_L)); // R6
    AST_EMPTY_AT_ZERO: assert property (@(posedge clk) disable iff (clr)
        st_empty == (level == '0)); // R8
    AST_DRAIN_START: assert property (@(posedge clk) disable iff (clr)
        $rose(snk_valid) |-> (level >= HALF_L)); // R7
    AST_REFUSED_HOLDS: assert property (@(posedge clk) disable iff (clr)
        (snk_valid && !snk_ready && !wr_valid) |=> (level == $past(level))); // R7
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (clr)
        (wr_valid && level == DEPTH_L && !snk_valid) |=> (level == DEPTH_L)); // R5

endmodule

// File: tb/audtx_fifo_bench.sv
`timescale 1ns/1ps
module audtx_fifo_bench;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iface_en = 1'b1;
    logic        tx_en = 1'b0;
    logic [1:0]  slot_sel = 2'b00;
    logic [1:0]  size_sel = 2'b00;
    logic        compact_req = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ur_clear = 1'b0;
    logic        link_busy = 1'b0;
    logic [2:0]  irq_en = 3'b000;
    logic        snk_valid;
    logic        snk_ready = 1'b0;
    logic [19:0] snk_left;
    logic [19:0] snk_right;
    logic        st_empty, st_half, st_full, st_underrun;
    logic [2:0]  irq_status;
    logic        irq;

    always #10 clk = ~clk;

    audtx_fifo #(.DEPTH(DEPTH)) u_audtx_fifo (
        .clk(clk), .rst(rst), .iface_en(iface_en), .tx_en(tx_en), .slot_sel(slot_sel),
        .size_sel(size_sel), .compact_req(compact_req), .wr_valid(wr_valid), .wr_data(wr_data),
        .ur_clear(ur_clear), .link_busy(link_busy), .irq_en(irq_en), .snk_valid(snk_valid),
        .snk_ready(snk_ready), .snk_left(snk_left), .snk_right(snk_right), .st_empty(st_empty),
        .st_half(st_half), .st_full(st_full), .st_underrun(st_underrun),
        .irq_status(irq_status), .irq(irq)
    );

    int nchk = 0;
    int nerr = 0;
    int ncap = 0;
    bit done = 1'b0;
    logic [19:0] cap_l [128];
    logic [19:0] cap_r [128];
    int unsigned exp_s [64];
    int nexp = 0;

    always @(posedge clk) begin
        if (!rst && snk_valid && snk_ready && ncap < 128) begin
            cap_l[ncap] = snk_left;
            cap_r[ncap] = snk_right;
            ncap = ncap + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic report();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    function automatic int unsigned bpad(int bits, int unsigned v);
        case (bits)
            12: return (v % 4096) * 256;
            16: return (v % 65536) * 16;
            18: return (v % 262144) * 4;
            default: return v % 1048576;
        endcase
    endfunction

    task automatic push(input logic [31:0] w);
        wr_data  = w;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic iface_off();
        iface_en = 1'b0;
        @(negedge clk);
        iface_en = 1'b1;
    endtask

    task automatic drain_cmp(input int npairs, input string tag);
        int base;
        base = ncap;
        slot_sel  = 2'b01;
        snk_ready = 1'b1;
        tx_en     = 1'b1;
        repeat (12) @(negedge clk);
        tx_en = 1'b0;
        chk({tag, " pair count"}, ncap - base, npairs);
        for (int i = 0; i < npairs; i++) begin
            chk({tag, " left"},  cap_l[base+i], exp_s[2*i]);
            chk({tag, " right"}, cap_r[base+i], exp_s[2*i+1]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 empty", st_empty, 1);
        chk("R1 half", st_half, 1);
        chk("R1 full", st_full, 0);
        chk("R1 underrun", st_underrun, 0);
        chk("R1 valid", snk_valid, 0);
        chk("R10 status after reset", irq_status, 3'b110);

        // Sweep all sizes with and without packing request: R2, R3, R4, R5, R6, R8, R9, R10
        for (int code = 0; code < 4; code++) begin
            for (int cmp = 0; cmp < 2; cmp++) begin
                int bits;
                bit pk;
                int lvl;
                int nw;
                string tag;
                logic [31:0] w;
                bits = (code == 0) ? 16 : (code == 1) ? 18 : (code == 2) ? 20 : 12;
                pk   = (cmp == 1) && (bits == 16 || bits == 12);
                tag  = pk ? "R3" : ((cmp == 1) ? "R4" : "R2");
                lvl  = 0;
                nexp = 0;
                iface_off();
                size_sel    = code[1:0];
                compact_req = cmp[0];
                nw = pk ? 4 : 9;
                for (int k = 0; k < nw; k++) begin
                    bit ok;
                    w  = 32'h9E3779B9 * (k + 1 + code * 11 + cmp * 5);
                    ok = pk ? (lvl + 2 < DEPTH) : (lvl < DEPTH);
                    push(w);
                    if (ok) begin
                        if (pk) begin
                            exp_s[nexp]   = bpad(bits, w & 32'h0000FFFF);
                            exp_s[nexp+1] = bpad(bits, w >> 16);
                            nexp = nexp + 2;
                            lvl  = lvl + 2;
                        end else begin
                            exp_s[nexp] = bpad(bits, w);
                            nexp = nexp + 1;
                            lvl  = lvl + 1;
                        end
                    end
                end
                chk("R5 full after overrun attempt", st_full, pk ? 0 : 1);
                chk("R6 empty cleared", st_empty, 0);
                chk("R6 half cleared", st_half, 0);
                drain_cmp(lvl / 2, tag);
                chk("R8 empty set", st_empty, 1);
                chk("R8 underrun set", st_underrun, 1);
                chk("R8 half set", st_half, 1);
                chk("R8 full cleared", st_full, 0);
                chk("R10 status all", irq_status, 3'b111);
                ur_clear = 1'b1;
                @(negedge clk);
                ur_clear = 1'b0;
                chk("R9 underrun cleared", st_underrun, 0);
                chk("R10 status after clear", irq_status, 3'b110);
            end
        end

        // Threshold and refusal: R7, R8
        begin
            int base;
            iface_off();
            size_sel = 2'd2; compact_req = 1'b0;
            slot_sel = 2'b10; tx_en = 1'b1; snk_ready = 1'b0;
            base = ncap;
            for (int k = 0; k < 3; k++) push(32'h100 + k);
            chk("R7 no offer below half", snk_valid, 0);
            push(32'h103);
            chk("R7 offer at half", snk_valid, 1);
            repeat (3) @(negedge clk);
            chk("R7 refused holds", ncap - base, 0);
            chk("R7 refused keeps half clear", st_half, 0);
            snk_ready = 1'b1;
            @(negedge clk);
            snk_ready = 1'b0;
            chk("R7 one pair taken", ncap - base, 1);
            chk("R7 burst continues", snk_valid, 1);
            @(negedge clk);
            chk("R7 burst ends on refusal", snk_valid, 0);
            chk("R8 half set below half", st_half, 1);
            chk("R8 not empty", st_empty, 0);
            snk_ready = 1'b1;
            repeat (3) @(negedge clk);
            chk("R7 no restart below half", ncap - base, 1);
            push(32'h104);
            push(32'h105);
            repeat (4) @(negedge clk);
            chk("R7 total pairs", ncap - base, 3);
            chk("R7 first left", cap_l[base], 20'h00100);
            chk("R7 first right", cap_r[base], 20'h00101);
            chk("R7 second left", cap_l[base+1], 20'h00102);
            chk("R7 third right", cap_r[base+2], 20'h00105);
            tx_en = 1'b0;
        end

        // No slot selected: R7
        begin
            int base;
            iface_off();
            base = ncap;
            slot_sel = 2'b00; tx_en = 1'b1; snk_ready = 1'b1;
            for (int k = 0; k < 4; k++) push(32'h200 + k);
            repeat (3) @(negedge clk);
            chk("R7 no slot no offer", snk_valid, 0);
            chk("R7 no slot no drain", ncap - base, 0);
            slot_sel = 2'b11;
            repeat (4) @(negedge clk);
            chk("R7 both slots drain", ncap - base, 2);
            tx_en = 1'b0;
        end

        // Interrupt masking: R10
        iface_off();
        irq_en = 3'b001; @(negedge clk);
        chk("R10 underrun masked", irq, 0);
        irq_en = 3'b010; @(negedge clk);
        chk("R10 tx enabled", irq, 1);
        link_busy = 1'b1; irq_en = 3'b100; @(negedge clk);
        chk("R10 complete blocked by busy", irq_status[2], 0);
        chk("R10 irq low when busy", irq, 0);
        link_busy = 1'b0; @(negedge clk);
        chk("R10 complete irq", irq, 1);
        irq_en = 3'b000;

        // Interface disable discards data: R11
        begin
            int base;
            size_sel = 2'd2; compact_req = 1'b0;
            push(32'h300); push(32'h301);
            chk("R11 pre empty", st_empty, 0);
            iface_off();
            chk("R11 empty", st_empty, 1);
            chk("R11 half", st_half, 1);
            chk("R11 underrun", st_underrun, 0);
            base = ncap;
            for (int k = 0; k < 4; k++) push(32'h400 + k);
            slot_sel = 2'b01; snk_ready = 1'b1; tx_en = 1'b1;
            repeat (4) @(negedge clk);
            tx_en = 1'b0;
            chk("R11 pairs", ncap - base, 2);
            chk("R11 fresh data first", cap_l[base], 20'h00400);
        end

        report();
    end

endmodule